// File: doc/BRIEF.md
# Serial Command Receiver with Memory Fill

This block takes 16-bit command words from a three-wire serial link: an active-low select, a serial clock and a data line. All three lines are synchronized into the system clock domain before any edge is detected. A word is accepted only if the select was low for exactly one full word of serial clock rising edges. The top bits of each accepted word form an opcode. Most opcodes become a one-cycle register write strobe toward the rest of the chip. One opcode sets up the busy pin, and one starts a fill of the whole display cell memory.

While a fill runs, an engine writes one fixed value to every cell in ascending address order, one cell per system clock, and keeps a busy flag raised. The host must not send commands while the flag is up. If the host pulls the select low during a fill, the fill ends at once. The busy pin reaches the outside only when it has been enabled by command, and its polarity can be inverted. Out of reset the pin is disabled and held low.

Top module: `sercmd_rx`

## Requirements
- R1: Bits are sampled on serial clock rising edges while the select is low, most significant bit first. When the select rises after exactly 16 edges, the word is accepted. An accepted word with opcode bits [15:12] in the range 0x0..0xD produces exactly one `reg_we` pulse, with `reg_addr` = bits [15:12] and `reg_data` = bits [11:0].
- R2: A transfer with fewer or more than 16 rising edges before the select rises produces no write and no fill.
- R3: Opcode 0xF starts a fill. `cell_we` is high on consecutive clocks for addresses 0 up to 559 in order, and each write carries `cell_data` = word bits [7:0].
- R4: The internal busy flag rises only as a fill starts. It stays high for every cell write of the fill and falls after the last cell.
- R5: While busy, a low level on the synchronized select ends the fill. No further cell writes follow and busy falls.
- R6: Opcode 0xE sets up the busy pin. Word bit 0 enables the pin and word bit 1 inverts it. While the pin is disabled, `busy_pin` is 0. While it is enabled, `busy_pin` equals busy XOR invert.
- R7: After reset there are no writes, the pin is disabled and `busy_pin` is 0.
- R8: Opcodes 0xE and 0xF never produce a `reg_we` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 4 | Register index (opcode) |
| reg_data | output | 12 | Register write value |
| cell_we | output | 1 | Cell memory write strobe |
| cell_addr | output | 10 | Cell memory address |
| cell_data | output | 8 | Cell memory write value |
| busy_pin | output | 1 | Busy indication after enable and polarity control |

## Verification
The hardest case to reach from the ports is an abort in the middle of a fill. The only trigger is a select level that has no serial clock edges behind it, and it must arrive while hundreds of cell writes are still pending. The bench starts a fill with the pin set to inverted polarity. About a hundred cycles later it lowers the select and holds it. It then checks that the count of cell writes stops below the full depth and stays there, that the pin shows idle, and that the edgeless select window later raises the select without producing a stray word.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
    localparam int OP_W = 4;
    localparam logic [OP_W-1:0] OP_FILL = 4'hF;
    localparam logic [OP_W-1:0] OP_PIN  = 4'hE;
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rst_val,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{rst_val[i]}};
            else        chain_q <= chain_d;
        end

        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sercmd_shift.sv
module sercmd_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              dat_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    localparam int CW = $clog2(WORD_W + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
    localparam logic [CW-1:0] CNT_OVER = CW'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic              sclk_p;
        logic              csn_p;
        logic              vld;
    } shift_s;

    shift_s st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vld    = 1'b0;
        st_d.sclk_p = sclk_s;
        st_d.csn_p  = csn_s;
        if (!csn_s) begin
            if (sclk_s && !st_q.sclk_p) begin
                st_d.sh = {st_q.sh[WORD_W-2:0], dat_s};
                if (st_q.cnt != CNT_OVER) st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (!st_q.csn_p && st_q.cnt == CNT_FULL) st_d.vld = 1'b1;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.csn_p  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.sh;

    // R1
    single_word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    // R2
    word_needs_select_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> csn_s);
endmodule

// File: rtl/sercmd_fill.sv
module sercmd_fill #(
    parameter int DEPTH = 560,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     abort,
    input  logic [DW-1:0]            val,
    output logic                     busy,
    output logic                     cell_we,
    output logic [$clog2(DEPTH)-1:0] cell_addr,
    output logic [DW-1:0]            cell_data
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] addr;
        logic [DW-1:0] val;
    } fill_s;

    fill_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (abort || st_q.addr == LAST) st_d.busy = 1'b0;
            else                            st_d.addr = st_q.addr + 1'b1;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.addr = '0;
            st_d.val  = val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign cell_we   = st_q.busy;
    assign cell_addr = st_q.addr;
    assign cell_data = st_q.val;

    // R3
    fill_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && cell_addr != LAST) |=> (busy && cell_addr == $past(cell_addr) + 1'b1));
    // R3
    fill_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cell_addr <= LAST);
    // R4
    busy_rise_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && cell_addr == '0));
    // R5
    abort_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> !busy);
endmodule

// File: rtl/sercmd_rx.sv
module sercmd_rx #(
    parameter int COLS   = 35,
    parameter int ROWS   = 16,
    parameter int WORD_W = 16,
    parameter int DW     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ser_csn,
    input  logic                                  ser_clk,
    input  logic                                  ser_dat,
    output logic                                  reg_we,
    output logic [sercmd_pkg::OP_W-1:0]           reg_addr,
    output logic [WORD_W-sercmd_pkg::OP_W-1:0]    reg_data,
    output logic                                  cell_we,
    output logic [$clog2(COLS*ROWS)-1:0]          cell_addr,
    output logic [DW-1:0]                         cell_data,
    output logic                                  busy_pin
);
    import sercmd_pkg::*;

    localparam int DEPTH = COLS * ROWS;
    localparam int RD_W  = WORD_W - OP_W;

    logic [2:0]        sync_out;
    logic              csn_s, sclk_s, dat_s;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              fill_busy;

    sercmd_sync #(.N(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b100),
        .din     ({ser_csn, ser_clk, ser_dat}),
        .dout    (sync_out)
    );
    assign {csn_s, sclk_s, dat_s} = sync_out;

    sercmd_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_s    (csn_s),
        .sclk_s   (sclk_s),
        .dat_s    (dat_s),
        .word_vld (word_vld),
        .word     (word)
    );

    typedef struct packed {
        logic            oe;
        logic            inv;
        logic            reg_we;
        logic [OP_W-1:0] reg_addr;
        logic [RD_W-1:0] reg_data;
        logic            start;
        logic [DW-1:0]   fill_val;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic [OP_W-1:0] op;

    always_comb begin
        op            = word[WORD_W-1 -: OP_W];
        ctl_d         = ctl_q;
        ctl_d.reg_we  = 1'b0;
        ctl_d.start   = 1'b0;
        if (word_vld) begin
            if (op == OP_FILL) begin
                ctl_d.start    = 1'b1;
                ctl_d.fill_val = word[DW-1:0];
            end else if (op == OP_PIN) begin
                ctl_d.oe  = word[0];
                ctl_d.inv = word[1];
            end else begin
                ctl_d.reg_we   = 1'b1;
                ctl_d.reg_addr = op;
                ctl_d.reg_data = word[RD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sercmd_fill #(.DEPTH(DEPTH), .DW(DW)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ctl_q.start),
        .abort     (!csn_s),
        .val       (ctl_q.fill_val),
        .busy      (fill_busy),
        .cell_we   (cell_we),
        .cell_addr (cell_addr),
        .cell_data (cell_data)
    );

    assign reg_we   = ctl_q.reg_we;
    assign reg_addr = ctl_q.reg_addr;
    assign reg_data = ctl_q.reg_data;
    assign busy_pin = ctl_q.oe & (fill_busy ^ ctl_q.inv);

    // R8
    no_reg_write_for_special_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr != OP_FILL && reg_addr != OP_PIN));
    // R6
    pin_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fill_busy) && ctl_q.oe && !ctl_q.inv) |-> busy_pin);
endmodule

// File: tb/sercmd_rx_bench.sv
module sercmd_rx_bench;
    logic clk = 0;
    logic rst_n = 0;
    logic ser_csn = 1, ser_clk = 0, ser_dat = 0;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [11:0] reg_data;
    logic        cell_we;
    logic [9:0]  cell_addr;
    logic [7:0]  cell_data;
    logic        busy_pin;

    int tests = 0, fails = 0;
    logic [15:0] exp_q[$];
    int   cell_idx = 0;
    logic [7:0] exp_val = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    sercmd_rx u_sercmd_rx (
        .clk(clk), .rst_n(rst_n), .ser_csn(ser_csn), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_data(reg_data),
        .cell_we(cell_we), .cell_addr(cell_addr), .cell_data(cell_data),
        .busy_pin(busy_pin)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        @(negedge clk) ser_csn = 0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            repeat (4) @(negedge clk);
            ser_clk = 1;
            repeat (4) @(negedge clk);
            ser_clk = 0;
        end
        repeat (4) @(negedge clk);
        ser_csn = 1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_reg(input logic [15:0] w);
        exp_q.push_back(w);
        send_bits({16'h0, w}, 16);
    endtask

    // scoreboard monitor: register writes (R1, R2, R8)
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2/R8 unexpected write", {reg_addr, reg_data}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({reg_addr, reg_data} == e, "R1 reg write", {reg_addr, reg_data}, e);
            end
        end
    end

    // monitor: cell writes in order (R3)
    always @(negedge clk) begin
        if (rst_n && cell_we) begin
            chk(cell_addr == 10'(cell_idx) && cell_data == exp_val, "R3 cell write",
                {cell_addr, cell_data}, {10'(cell_idx), exp_val});
            cell_idx++;
        end
    end

    task automatic run_fill(input logic [7:0] v, input logic pin_mid, input logic pin_idle);
        cell_idx = 0;
        exp_val  = v;
        send_bits({16'h0, 8'hF0, v}, 16);
        repeat (100) @(negedge clk);
        chk(busy_pin == pin_mid, "R4/R6 pin during fill", busy_pin, pin_mid);
        repeat (600) @(negedge clk);
        chk(cell_idx == 560, "R3/R4 fill count", cell_idx, 560);
        chk(busy_pin == pin_idle, "R4/R6 pin after fill", busy_pin, pin_idle);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(busy_pin == 0, "R7 pin in reset", busy_pin, 0);
        chk(reg_we == 0 && cell_we == 0, "R7 no writes in reset", {reg_we, cell_we}, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk(busy_pin == 0, "R7 pin after reset", busy_pin, 0);

        // R1 register writes, several patterns
        send_reg(16'h3ABC);
        send_reg(16'h0123);
        send_reg(16'hD555);
        // R2 short and long words dropped
        send_bits(32'h1234, 15);
        send_bits(32'h1_5678, 17);
        send_reg(16'h7001);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R1/R2 queue drained", exp_q.size(), 0);

        // R3/R4 fill with pin disabled (R6: pin stays 0)
        run_fill(8'hA5, 1'b0, 1'b0);
        // R6 enable normal polarity, R8 no write from 0xE
        send_bits(32'hE001, 16);
        run_fill(8'h3C, 1'b1, 1'b0);
        // R6 inverted polarity
        send_bits(32'hE003, 16);
        repeat (4) @(negedge clk);
        chk(busy_pin == 1, "R6 inverted idle", busy_pin, 1);

        // R5 abort
        cell_idx = 0;
        exp_val  = 8'hFF;
        send_bits(32'hF0FF, 16);
        repeat (100) @(negedge clk);
        chk(busy_pin == 0, "R6 inverted during fill", busy_pin, 0);
        ser_csn = 0;
        repeat (10) @(negedge clk);
        chk(busy_pin == 1, "R5 busy dropped on abort", busy_pin, 1);
        n = cell_idx;
        chk(n > 0 && n < 560, "R5 partial fill", n, 100);
        repeat (30) @(negedge clk);
        chk(cell_idx == n, "R5 no writes after abort", cell_idx, n);
        ser_csn = 1;
        repeat (10) @(negedge clk);
        send_reg(16'h2FED);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R1/R8 final queue", exp_q.size(), 0);
        chk(cell_idx == n, "R2 no fill from empty select window", cell_idx, n);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule